// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative side store that sits next to a direct-mapped cache. It keeps the lines the cache has just thrown out. The cache pushes a line in only when it evicts one. The buffer is asked only after the cache's own lookup has missed. Every entry has its own comparator. Each entry holds the full block address, meaning the cache tag joined with the set index, so a saved line can be matched for any set.

A lookup returns its answer one clock later: a hit flag, the index of the matching entry and that entry's line. On a hit, the cache takes the line back and hands over the line it is displacing. The cache writes that line into the same entry through the swap port. On a miss, the response raises a forward flag so that the request goes to the next lower level. New evictions fill the entries in insertion order. Once all entries are valid, the oldest insertion is overwritten.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `lkp_valid` high, and low otherwise.
- R3: A lookup whose full block address equals a valid entry's stored address reports `rsp_hit`=1, that entry's index on `rsp_idx` and its line on `rsp_line`. An address that differs in any bit does not match.
- R4: A lookup that matches no valid entry reports `rsp_hit`=0 and `rsp_fwd`=1. `rsp_fwd` is never high together with `rsp_hit`.
- R5: Evictions are written to entries 0, 1, 2, 3 in turn, starting at entry 0 after reset, and each one marks its entry valid.
- R6: When all entries are valid, a new eviction replaces the least recently inserted entry, and the old address no longer hits.
- R7: A swap writes its address and line into entry `swp_idx` and marks it valid. It does not move the insertion order.
- R8: A lookup compares against the contents held before the writes of its own cycle, so a line evicted in the same cycle is not yet found.
- R9: When a swap and an eviction fall in the same cycle and the eviction's slot equals `swp_idx`, the swap is written, the eviction is discarded and the insertion order does not advance.
- R10: If more than one valid entry matches, the lowest index is reported.
- R11: Lookups never change the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evc_valid | input | 1 | Eviction from the cache this cycle |
| evc_blk | input | BLK_W | Full block address of the evicted line |
| evc_line | input | LINE_W | Evicted line data |
| lkp_valid | input | 1 | Lookup request after a cache miss |
| lkp_blk | input | BLK_W | Full block address looked up |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found in the buffer |
| rsp_fwd | output | 1 | Lookup missed; go to the next level |
| rsp_idx | output | IDX_W | Matching entry index |
| rsp_line | output | LINE_W | Line data of the matching entry |
| swp_valid | input | 1 | Cache returns its displaced line |
| swp_idx | input | IDX_W | Entry that receives the displaced line |
| swp_blk | input | BLK_W | Block address of the displaced line |
| swp_line | input | LINE_W | Displaced line data |

## Verification
Two pairs of operations can fall in the same cycle.

The first pair is a lookup and an eviction of the same address. The bench drives both in one cycle and expects a miss. The following lookup of that address must then hit at the slot the eviction filled.

The second pair is a swap and an eviction aimed at the same slot. The bench lines the insertion order up with the swap index and drives both together. Later lookups must show that the swapped line is present and the evicted line is absent, and a further eviction must land in that same slot.

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int BLK_W   = 16,
  parameter int LINE_W  = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evc_valid,
  input  logic [BLK_W-1:0]  evc_blk,
  input  logic [LINE_W-1:0] evc_line,
  input  logic              lkp_valid,
  input  logic [BLK_W-1:0]  lkp_blk,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fwd,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [LINE_W-1:0] rsp_line,
  input  logic              swp_valid,
  input  logic [IDX_W-1:0]  swp_idx,
  input  logic [BLK_W-1:0]  swp_blk,
  input  logic [LINE_W-1:0] swp_line
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [BLK_W-1:0]   blk  [ENTRIES];
  logic [LINE_W-1:0]  line [ENTRIES];
  logic [IDX_W-1:0]   wp;

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx;
  logic               evc_take;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld[g] && (blk[g] == lkp_blk);
    end
  endgenerate

  assign evc_take = evc_valid && !(swp_valid && swp_idx == wp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      wp  <= '0;
    end else begin
      if (evc_take) begin
        vld[wp]  <= 1'b1;
        blk[wp]  <= evc_blk;
        line[wp] <= evc_line;
        wp       <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (swp_valid) begin
        vld[swp_idx]  <= 1'b1;
        blk[swp_idx]  <= swp_blk;
        line[swp_idx] <= swp_line;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= lkp_valid;
      rsp_hit   <= lkp_valid && (|match);
      rsp_idx   <= hit_idx;
      rsp_line  <= line[hit_idx];
    end
  end

  assign rsp_fwd = rsp_valid && !rsp_hit;

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> rsp_valid);
  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !rsp_valid);
  assert_fwd_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_fwd && rsp_hit));
  assert_hit_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  assert_swap_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swp_valid |=> vld[$past(swp_idx)]);

endmodule

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
  localparam int BW = 16;
  localparam int LW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evc_valid = 1'b0, lkp_valid = 1'b0, swp_valid = 1'b0;
  logic [BW-1:0] evc_blk = '0, lkp_blk = '0, swp_blk = '0;
  logic [LW-1:0] evc_line = '0, swp_line = '0;
  logic [1:0]    swp_idx = '0;
  logic          rsp_valid, rsp_hit, rsp_fwd;
  logic [1:0]    rsp_idx;
  logic [LW-1:0] rsp_line;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  victim_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .evc_valid(evc_valid), .evc_blk(evc_blk), .evc_line(evc_line),
    .lkp_valid(lkp_valid), .lkp_blk(lkp_blk),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fwd(rsp_fwd),
    .rsp_idx(rsp_idx), .rsp_line(rsp_line),
    .swp_valid(swp_valid), .swp_idx(swp_idx), .swp_blk(swp_blk), .swp_line(swp_line)
  );

  function automatic logic [LW-1:0] mk(input logic [BW-1:0] b);
    return {b, ~b, b ^ 16'h5a5a, b + 16'd1};
  endfunction

  // {kind(1:lookup,0:evict), blk, exp_hit, exp_idx}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 16'h0010, 1'b0, 2'd0},
    {1'b0, 16'h0010, 1'b0, 2'd0},
    {1'b0, 16'h0120, 1'b0, 2'd0},
    {1'b1, 16'h0120, 1'b1, 2'd1},
    {1'b1, 16'h0010, 1'b1, 2'd0},
    {1'b1, 16'h0110, 1'b0, 2'd0},
    {1'b0, 16'h0230, 1'b0, 2'd0},
    {1'b0, 16'h0340, 1'b0, 2'd0},
    {1'b1, 16'h0340, 1'b1, 2'd3},
    {1'b0, 16'h0450, 1'b0, 2'd0},
    {1'b1, 16'h0010, 1'b0, 2'd0},
    {1'b1, 16'h0450, 1'b1, 2'd0},
    {1'b1, 16'h0120, 1'b1, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs driven at negedge, response sampled at the next negedge
  task automatic cyc(input bit ev, input logic [BW-1:0] eb, input bit lk, input logic [BW-1:0] lb,
                     input bit sw, input logic [1:0] si, input logic [BW-1:0] sb);
    evc_valid = ev; evc_blk = eb; evc_line = mk(eb);
    lkp_valid = lk; lkp_blk = lb;
    swp_valid = sw; swp_idx = si; swp_blk = sb; swp_line = mk(sb);
    @(posedge clk); @(negedge clk);
    evc_valid = 0; lkp_valid = 0; swp_valid = 0;
  endtask

  task automatic look(input logic [BW-1:0] b, input bit eh, input logic [1:0] ei, input string req);
    cyc(0, '0, 1, b, 0, '0, '0);
    chk(rsp_valid === 1'b1, {req, " R2 valid"}, LW'(rsp_valid), 1);
    chk(rsp_hit === eh, {req, " hit"}, LW'(rsp_hit), LW'(eh));
    chk(rsp_fwd === !eh, {req, " R4 fwd"}, LW'(rsp_fwd), LW'(!eh));
    if (eh) begin
      chk(rsp_idx === ei, {req, " idx"}, LW'(rsp_idx), LW'(ei));
      chk(rsp_line === mk(b), {req, " R3 line"}, rsp_line, mk(b));
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rsp_valid === 1'b0, "R1 reset rsp_valid", LW'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        look(VEC[i][18:3], VEC[i][2], VEC[i][1:0], "R3/R5/R6/R11 vec");
      end else begin
        cyc(1, VEC[i][18:3], 0, '0, 0, '0, '0);
        chk(rsp_valid === 1'b0, "R2 no response", LW'(rsp_valid), 0);
      end
    end

    // R7: swap into entry 2, insertion order unchanged
    cyc(0, '0, 0, '0, 1, 2'd2, 16'h0777);
    look(16'h0777, 1, 2'd2, "R7 swapped");
    look(16'h0230, 0, 2'd0, "R7 replaced");
    cyc(1, 16'h0888, 0, '0, 0, '0, '0);
    look(16'h0888, 1, 2'd1, "R7 order kept");

    // R8: eviction and lookup in the same cycle
    cyc(1, 16'h0aaa, 1, 16'h0aaa, 0, '0, '0);
    chk(rsp_hit === 1'b0, "R8 same-cycle miss", LW'(rsp_hit), 0);
    look(16'h0aaa, 1, 2'd2, "R8 later hit");

    // R9: swap and eviction on the same slot (slot 3)
    cyc(1, 16'h0ccc, 0, '0, 1, 2'd3, 16'h0bbb);
    look(16'h0bbb, 1, 2'd3, "R9 swap kept");
    look(16'h0ccc, 0, 2'd0, "R9 evict dropped");
    cyc(1, 16'h0ddd, 0, '0, 0, '0, '0);
    look(16'h0ddd, 1, 2'd3, "R9 order held");
    look(16'h0bbb, 0, 2'd0, "R9 slot reused");

    // R10: duplicate address in entries 0 and 1
    cyc(0, '0, 0, '0, 1, 2'd1, 16'h0450);
    look(16'h0450, 1, 2'd0, "R10 lowest index");

    // R1: reset clears everything
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    look(16'h0ddd, 0, 2'd0, "R1 after reset");
    cyc(1, 16'h0eee, 0, '0, 0, '0, '0);
    look(16'h0eee, 1, 2'd0, "R5 restart at 0");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule